// File: doc/BRIEF.md
# Receive Interrupt Coalescer

This block decides when one receive channel interrupts its host. Received messages are counted as they arrive, and an elapsed-time counter runs from the first message still waiting. An interrupt is raised as soon as the message count reaches a programmed limit, or as soon as the time limit is reached, whichever comes first. A transmit link event also raises an interrupt, even when no messages are waiting. When the interrupt is raised, a 32-bit status word is latched. It holds a rolling 4-bit tag, the number of messages covered by the interrupt and a link flag.

The host services the interrupt and acknowledges it by writing the next tag value. Only then can another interrupt be raised, and that interrupt carries the tag that was written. A control register is changed through separate set and clear addresses. It holds a path-reset bit that keeps the unit idle, an interrupt-enable bit and an uncached-memory mode bit, which is passed on to the transfer engine. Time is counted in units of 100 µs. A prescaler produces these units from the system clock.

Top module: `rx_irq_coalescer`

## Requirements
- R1: After reset, irq and uncached are 0, status_word is 0, the path-reset control bit is set, the count limit is 16 and the time limit is 10.
- R2: Writing to address 0 sets, and writing to address 1 clears, exactly those control bits that are 1 in the written data. The control bits are uncached = bit 16, path reset = bit 17 and interrupt enable = bit 18. All other control bits are unchanged.
- R3: While the path-reset bit is set, message and link strobes are discarded, irq is 0 and status_word is 0. Once the bit is cleared, no interrupt follows unless new events arrive.
- R4: When the pending message count reaches the count limit, irq rises on the following clock edge. status_word[10:4] then holds the count and status_word[16] holds the link flag.
- R5: A lone pending message raises irq exactly time_limit × TICK_DIV + 1 cycles after the cycle of its strobe. TICK_DIV is the number of clock cycles in one 100 µs unit.
- R6: A link strobe with no messages pending raises irq on the next edge, with status_word[16] = 1 and a count of 0.
- R7: A write to address 3 acknowledges the interrupt and drops irq. Its data bits [3:0] become status_word[3:0] of the next interrupt. Tags wrap from 15 to 0.
- R8: While interrupt enable is 0, irq stays 0 and pending events are held. Setting the bit raises irq on the next edge if the trigger condition is already met.
- R9: After an interrupt and until the acknowledge, no further interrupt is raised and status_word holds. Messages arriving in that time accumulate, saturating at 127, and are reported by the next interrupt.
- R10: With no pending messages and no link event, irq never rises.
- R11: A write to address 2 loads the count limit from bits [7:0] and the time limit from bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 set control, 1 clear control, 2 limits, 3 acknowledge |
| wr_data | input | 32 | Register write data |
| msg_stb | input | 1 | One received message per cycle high |
| link_stb | input | 1 | Transmit link event |
| status_word | output | 32 | Tag [3:0], count [10:4], link [16] |
| irq | output | 1 | Interrupt request, level |
| uncached | output | 1 | Uncached-memory mode bit |

## Verification
A wrong pending count or a lost link flag appears in the status word latched at the very next interrupt, so every interrupt is compared against a predicted word. A timer or prescaler that is off by even one unit moves the rising edge of irq. Because of this, the time-limit and count-limit cases check irq on the exact cycle before the predicted rise and on the cycle of the rise. A stuck arming or tag state shows up as a missing interrupt, an extra interrupt or a wrong tag within one acknowledge round.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef enum logic [1:0] {
    REG_SET    = 2'd0,
    REG_CLR    = 2'd1,
    REG_LIMITS = 2'd2,
    REG_ACK    = 2'd3
  } rxc_reg_e;

  localparam int unsigned CTL_LO = 16;  // uncached
  localparam int unsigned CTL_HI = 18;  // interrupt enable
  localparam int unsigned LIM_W  = 8;
  localparam int unsigned TAG_W  = 4;
  localparam int unsigned CNT_W  = 7;

  function automatic logic [31:0] pack_status(logic [TAG_W-1:0] tag,
                                              logic [CNT_W-1:0] cnt,
                                              logic link);
    logic [31:0] w;
    w = '0;
    w[TAG_W-1:0] = tag;
    w[TAG_W+CNT_W-1:TAG_W] = cnt;
    w[16] = link;
    return w;
  endfunction
endpackage

// File: rtl/rxc_ctrl_regs.sv
module rxc_ctrl_regs
  import rxc_pkg::*;
#(
  parameter int unsigned DEF_CNT  = 16,
  parameter int unsigned DEF_TIME = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  output logic             unc_o,
  output logic             hold_o,
  output logic             ien_o,
  output logic [LIM_W-1:0] cnt_lim_o,
  output logic [LIM_W-1:0] time_lim_o,
  output logic             ack_stb_o,
  output logic [TAG_W-1:0] ack_tag_o
);
  localparam int unsigned CTL_N = CTL_HI - CTL_LO + 1;

  logic [CTL_N-1:0] ctl_q, ctl_d;
  logic [LIM_W-1:0] cl_q, cl_d, tl_q, tl_d;

  always_comb begin
    ctl_d = ctl_q;
    cl_d  = cl_q;
    tl_d  = tl_q;
    if (wr_en) begin
      case (rxc_reg_e'(wr_addr))
        REG_SET:    ctl_d = ctl_q | wr_data[CTL_HI:CTL_LO];
        REG_CLR:    ctl_d = ctl_q & ~wr_data[CTL_HI:CTL_LO];
        REG_LIMITS: begin
          cl_d = wr_data[LIM_W-1:0];
          tl_d = wr_data[2*LIM_W-1:LIM_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_N'(3'b010);
      cl_q  <= LIM_W'(DEF_CNT);
      tl_q  <= LIM_W'(DEF_TIME);
    end else begin
      ctl_q <= ctl_d;
      cl_q  <= cl_d;
      tl_q  <= tl_d;
    end
  end

  assign unc_o      = ctl_q[0];
  assign hold_o     = ctl_q[1];
  assign ien_o      = ctl_q[2];
  assign cnt_lim_o  = cl_q;
  assign time_lim_o = tl_q;
  assign ack_stb_o  = wr_en && (rxc_reg_e'(wr_addr) == REG_ACK);
  assign ack_tag_o  = wr_data[TAG_W-1:0];
endmodule

// File: rtl/rxc_timebase.sv
module rxc_timebase #(
  parameter int unsigned TICK_DIV = 10000,
  parameter int unsigned TIME_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  output logic [TIME_W-1:0] time_o
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [TIME_W-1:0] t_q, t_d;

  always_comb begin
    pre_d = pre_q;
    t_d   = t_q;
    if (clr || !run) begin
      pre_d = '0;
      t_d   = '0;
    end else if (pre_q == PRE_LAST) begin
      pre_d = '0;
      if (t_q != '1) t_d = t_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      t_q   <= '0;
    end else begin
      pre_q <= pre_d;
      t_q   <= t_d;
    end
  end

  assign time_o = t_q;
endmodule

// File: rtl/rxc_pending.sv
module rxc_pending #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             msg,
  input  logic             link,
  output logic [CNT_W-1:0] cnt_o,
  output logic             link_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lnk_q, lnk_d;

  always_comb begin
    cnt_d = cnt_q;
    lnk_d = lnk_q;
    if (clr) begin
      cnt_d = '0;
      lnk_d = 1'b0;
    end else if (take) begin
      cnt_d = CNT_W'(msg);
      lnk_d = link;
    end else begin
      if (msg && cnt_q != '1) cnt_d = cnt_q + 1'b1;
      lnk_d = lnk_q | link;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lnk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lnk_q <= lnk_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign link_o = lnk_q;
endmodule

// File: rtl/rx_irq_coalescer.sv
module rx_irq_coalescer
  import rxc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 10000,
  parameter int unsigned DEF_CNT  = 16,
  parameter int unsigned DEF_TIME = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        msg_stb,
  input  logic        link_stb,
  output logic [31:0] status_word,
  output logic        irq,
  output logic        uncached
);
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic             hold_q, ien_q, ack_stb;
  logic [TAG_W-1:0] ack_tag;
  logic [LIM_W-1:0] cnt_lim, time_lim;
  logic [CNT_W-1:0] pend_cnt;
  logic             pend_link;
  logic [LIM_W-1:0] elapsed;
  logic             raise;

  rxc_ctrl_regs #(.DEF_CNT(DEF_CNT), .DEF_TIME(DEF_TIME)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .unc_o(uncached), .hold_o(hold_q), .ien_o(ien_q),
    .cnt_lim_o(cnt_lim), .time_lim_o(time_lim),
    .ack_stb_o(ack_stb), .ack_tag_o(ack_tag)
  );

  rxc_pending #(.CNT_W(CNT_W)) u_pend (
    .clk(clk), .rst_n(srst_n), .clr(hold_q), .take(raise),
    .msg(msg_stb), .link(link_stb), .cnt_o(pend_cnt), .link_o(pend_link)
  );

  rxc_timebase #(.TICK_DIV(TICK_DIV), .TIME_W(LIM_W)) u_time (
    .clk(clk), .rst_n(srst_n), .clr(hold_q || raise),
    .run(pend_cnt != '0), .time_o(elapsed)
  );

  logic             armed_q, armed_d;
  logic             flag_q, flag_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic [31:0]      stat_q, stat_d;
  logic             cond;

  always_comb begin
    cond = pend_link ||
           ((pend_cnt != '0) &&
            ((LIM_W'(pend_cnt) >= cnt_lim) || (elapsed >= time_lim)));
    raise = armed_q && !flag_q && ien_q && !hold_q && !ack_stb && cond;

    armed_d = armed_q;
    flag_d  = flag_q;
    tag_d   = tag_q;
    stat_d  = stat_q;
    if (hold_q) begin
      armed_d = 1'b0;
      flag_d  = 1'b0;
      tag_d   = '0;
      stat_d  = '0;
    end else if (ack_stb) begin
      armed_d = 1'b1;
      flag_d  = 1'b0;
      tag_d   = ack_tag;
    end else if (raise) begin
      armed_d = 1'b0;
      flag_d  = 1'b1;
      stat_d  = pack_status(tag_q, pend_cnt, pend_link);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
      tag_q   <= '0;
      stat_q  <= '0;
    end else begin
      armed_q <= armed_d;
      flag_q  <= flag_d;
      tag_q   <= tag_d;
      stat_q  <= stat_d;
    end
  end

  assign irq         = flag_q && ien_q;
  assign status_word = stat_q;
endmodule

// File: rtl/rx_irq_coalescer_chk.sv
module rx_irq_coalescer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hold,
  input logic        ack_stb,
  input logic        irq,
  input logic [31:0] status_word
);
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!irq && status_word == 32'd0));

  p_status_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(irq)) |-> $stable(status_word));

  p_ack_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |=> !irq);

  p_rise_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (status_word[16] || status_word[10:4] != 7'd0));
endmodule

bind rx_irq_coalescer rx_irq_coalescer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hold(hold_q), .ack_stb(ack_stb),
  .irq(irq), .status_word(status_word)
);

// File: tb/rx_irq_coalescer_tb_top.sv
module rx_irq_coalescer_tb_top;
  localparam int unsigned TD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic        msg_stb = 1'b0;
  logic        link_stb = 1'b0;
  logic [31:0] status_word;
  logic        irq;
  logic        uncached;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] expq[$];
  string       tagq[$];

  always #5 clk = ~clk;

  rx_irq_coalescer #(.TICK_DIV(TD)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .msg_stb(msg_stb), .link_stb(link_stb),
    .status_word(status_word), .irq(irq), .uncached(uncached)
  );

  function automatic logic [31:0] sw(int tag, int cnt, int link);
    logic [31:0] w;
    w = '0;
    w[3:0] = tag[3:0];
    w[10:4] = cnt[6:0];
    w[16] = link[0];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: each rising irq is matched against the scoreboard
  logic irq_prev = 1'b0;
  always @(negedge clk) begin
    if (irq && !irq_prev) begin
      if (expq.size() == 0) begin
        check("R9/R10 unexpected irq", status_word, 32'hFFFF_FFFF);
      end else begin
        check(tagq.pop_front(), status_word, expq.pop_front());
      end
    end
    irq_prev <= irq;
  end

  task automatic expect_irq(string req, int tag, int cnt, int link);
    expq.push_back(sw(tag, cnt, link));
    tagq.push_back(req);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic msgs(int n);
    for (int i = 0; i < n; i++) begin
      msg_stb = 1'b1;
      @(posedge clk); #1;
    end
    msg_stb = 1'b0;
  endtask

  task automatic link_pulse();
    link_stb = 1'b1;
    @(posedge clk); #1;
    link_stb = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_irq(string req);
    int k = 0;
    while (!irq && k < 2000) begin idle(1); k++; end
    if (!irq) check(req, 32'd0, 32'd1);
    idle(1);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 status", status_word, 32'd0);
    check("R1 uncached", {31'd0, uncached}, 32'd0);

    // R3 strobes during path reset are discarded
    msgs(5);
    link_pulse();
    wr(2'd1, 32'h0002_0000);
    wr(2'd3, 32'd1);
    wr(2'd0, 32'h0004_0000);
    idle(60);
    check("R3 no irq after reset release", {31'd0, irq}, 32'd0);
    check("R3 status idle", status_word, 32'd0);

    // R2 set/clear touch only selected bits
    wr(2'd0, 32'h0001_0000);
    check("R2 uncached set", {31'd0, uncached}, 32'd1);
    wr(2'd1, 32'h0004_0000);
    wr(2'd0, 32'h0004_0000);
    check("R2 uncached kept", {31'd0, uncached}, 32'd1);
    wr(2'd1, 32'h0001_0000);
    check("R2 uncached clear", {31'd0, uncached}, 32'd0);

    // R4 default count limit 16
    expect_irq("R4 count limit status", 1, 16, 0);
    msgs(16);
    check("R4 irq not before", {31'd0, irq}, 32'd0);
    idle(1);
    check("R4 irq on next edge", {31'd0, irq}, 32'd1);

    // R9 accumulate while outstanding
    msgs(3);
    idle(50);
    check("R9 single irq held", {31'd0, irq}, 32'd1);
    check("R9 status held", status_word, sw(1, 16, 0));
    expect_irq("R9 accumulated status", 2, 3, 0);
    wr(2'd3, 32'd2);
    wait_irq("R9 irq after ack");
    msgs(130);
    expect_irq("R9 saturated count", 3, 127, 0);
    wr(2'd3, 32'd3);
    wait_irq("R9 saturated irq");
    wr(2'd3, 32'd4);
    check("R7 ack drops irq", {31'd0, irq}, 32'd0);

    // R5/R11 time limit 3 units, count limit 50
    wr(2'd2, 32'h0000_0332);
    expect_irq("R5 time limit status", 4, 1, 0);
    msgs(1);
    idle(3 * TD);
    check("R5 irq not before limit", {31'd0, irq}, 32'd0);
    idle(1);
    check("R5 irq at limit", {31'd0, irq}, 32'd1);
    wr(2'd3, 32'd5);

    // R11 count limit field
    wr(2'd2, 32'h0000_C802);
    expect_irq("R11 count limit 2 status", 5, 2, 0);
    msgs(2);
    idle(1);
    check("R11 irq at count 2", {31'd0, irq}, 32'd1);
    wr(2'd3, 32'd6);

    // R6 link alone
    expect_irq("R6 link status", 6, 0, 1);
    link_pulse();
    idle(1);
    check("R6 irq on link", {31'd0, irq}, 32'd1);
    wr(2'd3, 32'd7);

    // R8 enable gating
    wr(2'd1, 32'h0004_0000);
    msgs(2);
    idle(5);
    check("R8 no irq while disabled", {31'd0, irq}, 32'd0);
    expect_irq("R8 held status", 7, 2, 0);
    wr(2'd0, 32'h0004_0000);
    idle(1);
    check("R8 irq after enable", {31'd0, irq}, 32'd1);

    // R7 tag wrap
    wr(2'd3, 32'd15);
    expect_irq("R7 tag 15", 15, 0, 1);
    link_pulse();
    wait_irq("R7 irq tag 15");
    wr(2'd3, 32'd0);
    expect_irq("R7 tag wraps to 0", 0, 0, 1);
    link_pulse();
    wait_irq("R7 irq tag 0");
    wr(2'd3, 32'd1);

    // R10 quiet
    idle(100);
    check("R10 no irq without events", {31'd0, irq}, 32'd0);
    check("R10 scoreboard drained", expq.size(), 32'd0);

    // R3 path reset clears status
    wr(2'd0, 32'h0002_0000);
    idle(1);
    check("R3 status cleared by path reset", status_word, 32'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule